// File: doc/BRIEF.md
# SD Command Issue Engine

This block issues commands on the CMD line of an SD card host. Software loads a 32-bit argument, a timeout start value and a command word through a small register port. Writing the command word with its start flag set launches a 48-bit command frame with a computed CRC7. The engine can then wait for a 48-bit or 136-bit response, verify the response CRC7, and optionally wait for the card to release busy on DAT0. All waiting is bounded by a programmable timeout counter.

The start flag reads back as set for the whole command and is cleared by hardware at the end. A sticky fail flag in the command word, together with write-one-to-clear status bits, reports a timeout or a CRC mismatch. The captured response reads back as four 32-bit words. Card clock generation is outside the block: a one-cycle `tick_i` strobe marks each card-clock bit period. The engine drives a new CMD bit on a tick and samples CMD and DAT0 on a tick.

Top module: `sdc_cmd_engine`

## Requirements
- R1: After reset the command word (address 0) and the status word (address 3) read 0, the timeout word (address 2) reads TOUT_RST, `cmd_o` is 1 and `cmd_oe_o` is 0.
- R2: The argument (address 1) and timeout (address 2) words read back what was last written. Response words sit at addresses 4 to 7, with word k at address 4+k.
- R3: A write to address 0 with bit 15 set while bit 15 reads 0 starts a command and latches the command fields: index in bits 5:0, read bit 6, write bit 7, long response bit 9, no response bit 10, busy-wait bit 11. Bit 15 reads 1 until the command ends and then reads 0. The fail flag, bit 14, is cleared at start.
- R4: The frame is 48 bits sent MSB first: 0, 1, the 6-bit index, the 32-bit argument, CRC7 (polynomial x^7+x^3+1, zero seed) over those first 40 bits, then 1. `cmd_oe_o` rises on the clock after the start write and presents bit 0. Each tick advances one bit, and `cmd_oe_o` falls on the 48th tick. Outside a frame `cmd_o` is 1.
- R5: With timeout start value T, a response start bit (CMD sampled 0) on any of the first T+1 ticks after the frame's last tick is accepted.
- R6: A short response is 48 bits. Word 0 receives frame bits 39:8 (frame bit 47 is the start bit), and words 1 to 3 read 0. Its CRC7 covers frame bits 47:8 and is compared with bits 7:1.
- R7: A long response (bit 9) is 136 bits. Words 0 to 3 receive frame bits 127:0, with word 0 holding bits 31:0. Its CRC7 covers frame bits 127:8 and is compared with bits 7:1.
- R8: A response CRC mismatch sets the fail flag and status bit 4, ends the command without a busy phase, and still stores the response words.
- R9: If no start bit arrives within the window of R5, or if busy is not released within T+1 ticks, the fail flag and status bit 6 are set and the command ends.
- R10: With busy-wait set, after the response (or after the frame when no response is selected) the engine samples DAT0 on each tick. On DAT0 high it sets status bit 10 and ends; while DAT0 stays low the start flag stays 1.
- R11: Writing address 3 clears exactly the status bits written as 1.
- R12: A command-word write while bit 15 reads 1 is ignored: no second frame, and the command fields are unchanged.
- R13: With no response and no busy-wait, the start flag reads 0 on the clock at which `cmd_oe_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe per card-clock bit period |
| we_i | input | 1 | Register write enable |
| waddr_i | input | 3 | Register write address |
| wdata_i | input | 32 | Register write data |
| raddr_i | input | 3 | Register read address |
| rdata_o | output | 32 | Register read data (combinational) |
| cmd_o | output | 1 | CMD line output value |
| cmd_oe_o | output | 1 | CMD line output enable |
| cmd_i | input | 1 | CMD line sampled value |
| dat0_i | input | 1 | DAT0 line, low while the card is busy |

## Verification
A wrong bit counter or CRC state shows on `cmd_o` on the very tick the bad bit goes out. The bench's per-clock frame model flags it there, long before any completion status. A wrong timeout window shows as a changed outcome exactly at the T versus T+1 boundary. A wrong receive length or CRC range shows as a wrong word or a spurious status bit 4 within a clock of the last response tick. A stuck sequencer state shows as a start flag that never clears, or as a second frame after an ignored start.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_TX, ST_WAIT, ST_RX, ST_BUSY} state_e;

  localparam logic [2:0] A_CMD  = 3'd0;
  localparam logic [2:0] A_ARG  = 3'd1;
  localparam logic [2:0] A_TOUT = 3'd2;
  localparam logic [2:0] A_STS  = 3'd3;

  localparam int B_RD    = 6;
  localparam int B_WR    = 7;
  localparam int B_LONG  = 9;
  localparam int B_NORSP = 10;
  localparam int B_BUSYW = 11;
  localparam int B_START = 15;

  localparam int S_CRC  = 4;
  localparam int S_TOUT = 6;
  localparam int S_BSY  = 10;

  localparam int IDX_W     = 6;
  localparam int ARG_W     = 32;
  localparam int CRC_W     = 7;
  localparam int SHORT_W   = 48;
  localparam int LONG_W    = 136;
  localparam int HDR_W     = 8;
  localparam int RSP_WORDS = 4;
endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7 #(
  parameter int           W    = 7,
  parameter logic [W-1:0] POLY = 7'h09
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb    = bit_i ^ crc_q[W-1];
  assign crc_o = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clr_i)   crc_q <= '0;
    else if (en_i) begin
      // shift mode drains the remainder MSB first
      if (shift_i) crc_q <= {crc_q[W-2:0], 1'b0};
      else         crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end
endmodule

// File: rtl/sdc_cmd_tx.sv
module sdc_cmd_tx #(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32,
  parameter int CRC_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [ARG_W-1:0] arg_i,
  input  logic             tick_i,
  output logic             cmd_o,
  output logic             oe_o,
  output logic             done_o
);
  localparam int BODY_W  = 2 + IDX_W + ARG_W;
  localparam int FRAME_W = BODY_W + CRC_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] BODY_END = CNT_W'(BODY_W);
  localparam logic [CNT_W-1:0] CRC_END  = CNT_W'(BODY_W + CRC_W);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_W - 1);

  logic [BODY_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              active_q;
  logic              in_body, in_crc, step;
  logic [CRC_W-1:0]  crc;

  assign in_body = cnt_q < BODY_END;
  assign in_crc  = !in_body && (cnt_q < CRC_END);
  assign step    = tick_i && active_q;

  sdc_crc7 #(.W(CRC_W)) i_crc (
    .clk_i, .rst_ni,
    .clr_i  (load_i),
    .en_i   (step && (in_body || in_crc)),
    .shift_i(in_crc),
    .bit_i  (sh_q[BODY_W-1]),
    .crc_o  (crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      sh_q     <= {2'b01, idx_i, arg_i};
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (step) begin
      if (in_body) sh_q <= {sh_q[BODY_W-2:0], 1'b0};
      if (cnt_q == LAST) active_q <= 1'b0;
      else               cnt_q    <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (!active_q)    cmd_o = 1'b1;
    else if (in_body) cmd_o = sh_q[BODY_W-1];
    else if (in_crc)  cmd_o = crc[CRC_W-1];
    else              cmd_o = 1'b1;
  end

  assign oe_o   = active_q;
  assign done_o = step && (cnt_q == LAST);
endmodule

// File: rtl/sdc_resp_rx.sv
module sdc_resp_rx #(
  parameter int SHORT_W = 48,
  parameter int LONG_W  = 136,
  parameter int HDR_W   = 8,
  parameter int CRC_W   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              long_i,
  input  logic              cmd_i,
  output logic              start_o,
  output logic              done_o,
  output logic              crc_ok_o,
  output logic [LONG_W-1:0] frame_o
);
  localparam int CNT_W = $clog2(LONG_W + 1);
  localparam logic [CNT_W-1:0] S_LO   = CNT_W'(1);
  localparam logic [CNT_W-1:0] S_HI   = CNT_W'(SHORT_W - CRC_W - 2);
  localparam logic [CNT_W-1:0] S_LAST = CNT_W'(SHORT_W - 1);
  localparam logic [CNT_W-1:0] L_LO   = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] L_HI   = CNT_W'(LONG_W - CRC_W - 2);
  localparam logic [CNT_W-1:0] L_LAST = CNT_W'(LONG_W - 1);

  logic [LONG_W-1:0] sh_q;
  logic [CNT_W-1:0]  n_q, lo, hi, last;
  logic              active_q, done_q, step;
  logic [CRC_W-1:0]  crc;

  assign lo      = long_i ? L_LO : S_LO;
  assign hi      = long_i ? L_HI : S_HI;
  assign last    = long_i ? L_LAST : S_LAST;
  assign step    = en_i && tick_i && active_q;
  assign start_o = en_i && tick_i && !active_q && !done_q && !cmd_i;

  sdc_crc7 #(.W(CRC_W)) i_crc (
    .clk_i, .rst_ni,
    .clr_i  (start_o),
    .en_i   (step && (n_q >= lo) && (n_q <= hi)),
    .shift_i(1'b0),
    .bit_i  (cmd_i),
    .crc_o  (crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      n_q      <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_o) begin
        sh_q     <= {sh_q[LONG_W-2:0], 1'b0};
        n_q      <= CNT_W'(1);
        active_q <= 1'b1;
      end else if (step) begin
        sh_q <= {sh_q[LONG_W-2:0], cmd_i};
        n_q  <= n_q + 1'b1;
        if (n_q == last) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assign done_o   = done_q;
  assign crc_ok_o = (crc == sh_q[CRC_W:1]);
  assign frame_o  = sh_q;
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
  import sdc_pkg::*;
#(
  parameter int              TOUT_W   = 32,
  parameter logic [TOUT_W-1:0] TOUT_RST = TOUT_W'(32'h0010_0000)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        we_i,
  input  logic [2:0]  waddr_i,
  input  logic [31:0] wdata_i,
  input  logic [2:0]  raddr_i,
  output logic [31:0] rdata_o,
  output logic        cmd_o,
  output logic        cmd_oe_o,
  input  logic        cmd_i,
  input  logic        dat0_i
);
  localparam int PAY_HI = SHORT_W - HDR_W - 1;
  localparam int PAY_LO = CRC_W + 1;

  state_e             state_q, state_d;
  logic [TOUT_W-1:0]  tout_q, tcnt_q, tcnt_d;
  logic [IDX_W-1:0]   idx_q;
  logic [ARG_W-1:0]   arg_q;
  logic               rd_q, wr_q, long_q, norsp_q, busyw_q, fail_q, start_q;
  logic               sts_crc_q, sts_to_q, sts_bsy_q;
  logic [31:0]        rsp_q [RSP_WORDS];
  logic               go, fin, e_crc, e_to, e_bsy;
  logic               tx_done, rx_start, rx_done, rx_crc_ok;
  logic [LONG_W-1:0]  rx_frame;

  assign go = we_i && (waddr_i == A_CMD) && wdata_i[B_START] && !start_q;

  sdc_cmd_tx #(.IDX_W(IDX_W), .ARG_W(ARG_W), .CRC_W(CRC_W)) i_tx (
    .clk_i, .rst_ni,
    .load_i(go),
    .idx_i (wdata_i[IDX_W-1:0]),
    .arg_i (arg_q),
    .tick_i,
    .cmd_o,
    .oe_o  (cmd_oe_o),
    .done_o(tx_done)
  );

  sdc_resp_rx #(.SHORT_W(SHORT_W), .LONG_W(LONG_W), .HDR_W(HDR_W), .CRC_W(CRC_W)) i_rx (
    .clk_i, .rst_ni,
    .en_i    ((state_q == ST_WAIT) || (state_q == ST_RX)),
    .tick_i,
    .long_i  (long_q),
    .cmd_i,
    .start_o (rx_start),
    .done_o  (rx_done),
    .crc_ok_o(rx_crc_ok),
    .frame_o (rx_frame)
  );

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    fin     = 1'b0;
    e_crc   = 1'b0;
    e_to    = 1'b0;
    e_bsy   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (go) state_d = ST_TX;
      ST_TX: if (tx_done) begin
        if (!norsp_q)     begin state_d = ST_WAIT; tcnt_d = tout_q; end
        else if (busyw_q) begin state_d = ST_BUSY; tcnt_d = tout_q; end
        else              begin state_d = ST_IDLE; fin = 1'b1; end
      end
      ST_WAIT: begin
        if (rx_start) state_d = ST_RX;
        else if (tick_i) begin
          if (tcnt_q == '0) begin state_d = ST_IDLE; fin = 1'b1; e_to = 1'b1; end
          else tcnt_d = tcnt_q - 1'b1;
        end
      end
      ST_RX: if (rx_done) begin
        if (!rx_crc_ok)   begin state_d = ST_IDLE; fin = 1'b1; e_crc = 1'b1; end
        else if (busyw_q) begin state_d = ST_BUSY; tcnt_d = tout_q; end
        else              begin state_d = ST_IDLE; fin = 1'b1; end
      end
      ST_BUSY: if (tick_i) begin
        if (dat0_i)             begin state_d = ST_IDLE; fin = 1'b1; e_bsy = 1'b1; end
        else if (tcnt_q == '0)  begin state_d = ST_IDLE; fin = 1'b1; e_to = 1'b1; end
        else tcnt_d = tcnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      start_q <= 1'b0;
      fail_q  <= 1'b0;
      idx_q   <= '0;
      {rd_q, wr_q, long_q, norsp_q, busyw_q} <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      if (go) begin
        start_q <= 1'b1;
        fail_q  <= 1'b0;
        idx_q   <= wdata_i[IDX_W-1:0];
        rd_q    <= wdata_i[B_RD];
        wr_q    <= wdata_i[B_WR];
        long_q  <= wdata_i[B_LONG];
        norsp_q <= wdata_i[B_NORSP];
        busyw_q <= wdata_i[B_BUSYW];
      end else begin
        if (fin)           start_q <= 1'b0;
        if (e_crc || e_to) fail_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arg_q  <= '0;
      tout_q <= TOUT_RST;
    end else if (we_i) begin
      if (waddr_i == A_ARG)  arg_q  <= wdata_i;
      if (waddr_i == A_TOUT) tout_q <= wdata_i[TOUT_W-1:0];
    end
  end

  // write-one-to-clear; a same-cycle hardware event wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {sts_crc_q, sts_to_q, sts_bsy_q} <= '0;
    end else begin
      sts_crc_q <= e_crc || (sts_crc_q && !(we_i && waddr_i == A_STS && wdata_i[S_CRC]));
      sts_to_q  <= e_to  || (sts_to_q  && !(we_i && waddr_i == A_STS && wdata_i[S_TOUT]));
      sts_bsy_q <= e_bsy || (sts_bsy_q && !(we_i && waddr_i == A_STS && wdata_i[S_BSY]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < RSP_WORDS; k++) rsp_q[k] <= '0;
    end else if (rx_done) begin
      for (int k = 0; k < RSP_WORDS; k++) begin
        if (long_q)      rsp_q[k] <= rx_frame[32*k +: 32];
        else if (k == 0) rsp_q[k] <= rx_frame[PAY_HI:PAY_LO];
        else             rsp_q[k] <= '0;
      end
    end
  end

  always_comb begin
    unique case (raddr_i)
      A_CMD:   rdata_o = {16'b0, start_q, fail_q, 2'b0, busyw_q, norsp_q, long_q,
                          1'b0, wr_q, rd_q, idx_q};
      A_ARG:   rdata_o = arg_q;
      A_TOUT:  rdata_o = 32'(tout_q);
      A_STS:   rdata_o = {21'b0, sts_bsy_q, 3'b0, sts_to_q, 1'b0, sts_crc_q, 4'b0};
      default: rdata_o = rsp_q[raddr_i[1:0]];
    endcase
  end
endmodule

// File: rtl/sdc_cmd_engine_chk.sv
module sdc_cmd_engine_chk
  import sdc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             we_i,
  input logic [2:0]       waddr_i,
  input logic [31:0]      wdata_i,
  input logic             cmd_o,
  input logic             cmd_oe_o,
  input logic             start_q,
  input logic             fail_q,
  input logic [IDX_W-1:0] idx_q,
  input logic             sts_to_q,
  input logic             sts_bsy_q,
  input state_e           state_q
);
  // R4
  oe_in_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_oe_o |-> start_q);
  // R4
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_oe_o |-> cmd_o);
  // R4
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_oe_o && $past(cmd_oe_o) && !$past(tick_i)) |-> $stable(cmd_o));
  // R3
  start_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_q) |-> $past(we_i && waddr_i == A_CMD && wdata_i[B_START]));
  // R9
  tout_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_to_q) |-> fail_q);
  // R12
  ignore_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && we_i && waddr_i == A_CMD) |=> $stable(idx_q));
  // R10
  busy_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_bsy_q) |-> $past(state_q) == ST_BUSY);
endmodule

bind sdc_cmd_engine sdc_cmd_engine_chk i_chk (
  .clk_i, .rst_ni, .tick_i, .we_i, .waddr_i, .wdata_i, .cmd_o, .cmd_oe_o,
  .start_q, .fail_q, .idx_q, .sts_to_q, .sts_bsy_q, .state_q
);

// File: tb/test_sdc_cmd_engine.sv
`timescale 1ns/1ps
module test_sdc_cmd_engine;
  localparam logic [31:0] TOUT_DEF = 32'h0010_0000;
  localparam logic [31:0] F_LONG = 32'h200, F_NORSP = 32'h400, F_BUSYW = 32'h800, F_GO = 32'h8000;

  logic clk = 0, rst_n = 0, tick = 0, we = 0, cmd_in = 1, dat0 = 1;
  logic [2:0] waddr = 0, raddr = 0;
  logic [31:0] wdata = 0, rdata;
  logic cmd_o, cmd_oe;
  int checks = 0, errors = 0, tcnt_b = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sdc_cmd_engine i_sdc_cmd_engine (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata), .cmd_o(cmd_o), .cmd_oe_o(cmd_oe), .cmd_i(cmd_in), .dat0_i(dat0)
  );

  always @(negedge clk) begin
    tcnt_b <= (tcnt_b + 1) % 4;
    tick   <= (tcnt_b == 3);
  end

  function automatic logic [6:0] crc7(input logic [135:0] v, input int hi, input int lo);
    logic [6:0] c = 0;
    for (int i = hi; i >= lo; i--) begin
      logic fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] cmd_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [135:0] v = '0;
    v[47:8] = {2'b01, idx, arg};
    v[7:1]  = crc7(v, 47, 8);
    v[0]    = 1'b1;
    return v[47:0];
  endfunction

  // behavioural reference for the CMD output, compared every clock
  logic [31:0] arg_shadow = 0;
  logic [47:0] mdl_frame = '1;
  int  mdl_pos = 0;
  bit  mdl_tx = 0, mdl_busy = 0, mdl_clr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mdl_tx <= 0; mdl_busy <= 0; mdl_pos <= 0;
    end else begin
      if (mdl_clr) mdl_busy <= 0;
      if (mdl_tx && tick) begin
        if (mdl_pos == 47) mdl_tx <= 0;
        else mdl_pos <= mdl_pos + 1;
      end
      if (we && waddr == 3'd0 && wdata[15] && !mdl_busy) begin
        mdl_tx <= 1; mdl_pos <= 0; mdl_busy <= 1;
        mdl_frame <= cmd_frame(wdata[5:0], arg_shadow);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic eb;
      eb = mdl_tx ? mdl_frame[47 - mdl_pos] : 1'b1;
      checks++;
      if (cmd_oe !== mdl_tx || cmd_o !== eb) begin
        errors++;
        $display("FAIL R4 cmd line pos %0d act oe=%b bit=%b exp oe=%b bit=%b",
                 mdl_pos, cmd_oe, cmd_o, mdl_tx, eb);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; waddr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    raddr = a; #1; v = rdata;
  endtask

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [31:0] flags);
    wr(3'd1, arg);
    arg_shadow = arg;
    wr(3'd0, flags | F_GO | {26'b0, idx});
  endtask

  task automatic wait_done;
    logic [31:0] v;
    int n = 0;
    do begin @(negedge clk); rd(3'd0, v); n++; end while (v[15] && n < 20000);
    @(negedge clk); mdl_clr = 1; @(negedge clk); mdl_clr = 0;
  endtask

  task automatic drive_bit(input logic b);
    cmd_in = b;
    do @(posedge clk); while (!tick);
    @(negedge clk);
  endtask

  task automatic card_reply(input int d, input logic [135:0] fr, input int len);
    while (!cmd_oe) @(negedge clk);
    while (cmd_oe) @(negedge clk);
    repeat (d) drive_bit(1'b1);
    for (int i = len - 1; i >= 0; i--) drive_bit(fr[i]);
    cmd_in = 1;
  endtask

  function automatic logic [135:0] short_rsp(input logic [5:0] idx, input logic [31:0] pay);
    logic [135:0] v = '0;
    v[47:8] = {2'b00, idx, pay};
    v[7:1]  = crc7(v, 47, 8);
    v[0]    = 1'b1;
    return v;
  endfunction

  function automatic logic [135:0] long_rsp(input logic [119:0] pay);
    logic [135:0] v = '0;
    v[135:128] = 8'h3F;
    v[127:8]   = pay;
    v[7:1]     = crc7(v, 127, 8);
    v[0]       = 1'b1;
    return v;
  endfunction

  initial begin
    #600000;
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [135:0] fr;
    repeat (3) @(negedge clk);
    rd(3'd0, v); check("R1 cmd word", v, 0);
    rd(3'd3, v); check("R1 status", v, 0);
    rd(3'd2, v); check("R1 timeout", v, TOUT_DEF);
    check("R1 cmd_o/oe", {cmd_o, cmd_oe}, 32'b10);
    rst_n = 1;
    @(negedge clk);

    // R2 register readback
    wr(3'd1, 32'hA5A5_0F0F); rd(3'd1, v); check("R2 arg", v, 32'hA5A5_0F0F);
    wr(3'd2, 32'd10);        rd(3'd2, v); check("R2 timeout", v, 32'd10);

    // R13 / R3 no-response command
    issue(6'd0, 32'h0, F_NORSP | 32'h40);
    rd(3'd0, v); check("R3 start set", v, 32'h8440);
    while (cmd_oe) @(negedge clk);
    rd(3'd0, v); check("R13 start clear at frame end", v[15], 0);
    wait_done;

    // R6 / R5 short response, delay 2 ticks
    fr = short_rsp(6'd17, 32'hCAFE_1234);
    issue(6'd17, 32'h0000_1000, 0);
    card_reply(2, fr, 48);
    wait_done;
    rd(3'd4, v); check("R6 word0", v, 32'hCAFE_1234);
    rd(3'd5, v); check("R6 word1", v, 0);
    rd(3'd7, v); check("R6 word3", v, 0);
    rd(3'd0, v); check("R5 no fail", v[14], 0);

    // R7 long response
    fr = long_rsp({32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 24'h55AA33});
    issue(6'd2, 32'h0, F_LONG);
    card_reply(1, fr, 136);
    wait_done;
    rd(3'd4, v); check("R7 word0", v, fr[31:0]);
    rd(3'd5, v); check("R7 word1", v, fr[63:32]);
    rd(3'd6, v); check("R7 word2", v, fr[95:64]);
    rd(3'd7, v); check("R7 word3", v, fr[127:96]);
    rd(3'd3, v); check("R7 status clean", v, 0);

    // R8 CRC error on short response with busy-wait requested
    fr = short_rsp(6'd7, 32'h0BAD_0BAD);
    fr[3] = ~fr[3];
    issue(6'd7, 32'h0, F_BUSYW);
    card_reply(0, fr, 48);
    wait_done;
    rd(3'd0, v); check("R8 fail flag", v[14], 1);
    rd(3'd3, v); check("R8 status crc only", v, 32'h10);
    rd(3'd4, v); check("R8 word stored", v, 32'h0BAD_0BAD);

    // R11 write-one-to-clear
    wr(3'd3, 32'h40); rd(3'd3, v); check("R11 other bits kept", v, 32'h10);
    wr(3'd3, 32'h10); rd(3'd3, v); check("R11 cleared", v, 0);

    // R5 boundary: start bit on tick T+1 accepted
    wr(3'd2, 32'd3);
    fr = short_rsp(6'd9, 32'h1111_2222);
    issue(6'd9, 32'h0, 0);
    card_reply(3, fr, 48);
    wait_done;
    rd(3'd0, v); check("R5 last tick accepted", v[14], 0);
    rd(3'd4, v); check("R5 word0", v, 32'h1111_2222);

    // R9 one tick late: timeout
    fr = short_rsp(6'd9, 32'h3333_4444);
    issue(6'd9, 32'h0, 0);
    card_reply(4, fr, 48);
    wait_done;
    rd(3'd0, v); check("R9 fail flag", v[14], 1);
    rd(3'd3, v); check("R9 status timeout", v, 32'h40);
    rd(3'd4, v); check("R9 words untouched", v, 32'h1111_2222);

    // R3 fail cleared by next start; R12 start while busy ignored
    wr(3'd3, 32'h450);
    issue(6'd2, 32'h0, F_NORSP);
    rd(3'd0, v); check("R3 fail cleared at start", v[14], 0);
    wr(3'd0, F_GO | F_NORSP | 32'd5);
    wait_done;
    rd(3'd0, v); check("R12 fields unchanged", v[5:0], 2);
    repeat (100) @(negedge clk);
    check("R12 no second frame", cmd_oe, 0);

    // R10 busy-wait released
    wr(3'd2, 32'd100);
    dat0 = 0;
    fr = short_rsp(6'd12, 32'h0000_0900);
    issue(6'd12, 32'h0, F_BUSYW);
    card_reply(1, fr, 48);
    repeat (3) drive_bit(1'b1);
    rd(3'd0, v); check("R10 start held while busy", v[15], 1);
    dat0 = 1;
    wait_done;
    rd(3'd3, v); check("R10 busy done status", v, 32'h400);
    rd(3'd0, v); check("R10 no fail", v[14], 0);

    // R10 / R9 busy never released, no-response busy-wait
    wr(3'd3, 32'h450);
    wr(3'd2, 32'd4);
    dat0 = 0;
    issue(6'd38, 32'h0, F_NORSP | F_BUSYW);
    wait_done;
    rd(3'd3, v); check("R9 busy timeout status", v, 32'h40);
    rd(3'd0, v); check("R9 busy timeout fail", v[14], 1);
    dat0 = 1;

    repeat (10) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule